// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the architectural registers of a 32-bit processor core with seven operating modes. Sixteen registers are visible at any time, r0 to r15, with r13 the stack pointer, r14 the link register and r15 the program counter. Which physical register answers a given register number depends on the current mode. Registers r0 to r7 and r15 are common to every mode. The fast-interrupt mode has private copies of r8 to r14. Every other exception mode has private r13 and r14 only. User and system modes share one set. There are 31 general registers in all, which together with the current status and five saved status words gives 37 physical registers.

The current status word holds the sign, zero, carry and overflow flags, the two interrupt masks and a 5-bit mode field. When an exception is taken, the block picks the winning request, saves the current status into the target mode's saved status word, and writes the return address into that mode's r14. It switches the mode, sets the interrupt masks and, one cycle later, presents the vector address. A return request copies the current mode's saved status back into the current status word. Two combinational read ports and one write port serve the datapath.

Top module: `mode_banked_regs`

## Requirements
- R1: After a synchronous active-low reset, the mode is supervisor (10011), both interrupt masks (bit 7 normal, bit 6 fast) are set, all four flags are clear, every general and saved register reads zero, and vec_valid is low.
- R2: Both read ports are combinational, and they return the register selected under the current mode. Registers r0–r7 and r15 are one physical copy shared by all modes.
- R3: In fast-interrupt mode (10001), r8–r14 are private to that mode. In every other mode, r8–r12 are the user copies.
- R4: Interrupt (10010), supervisor, abort (10111) and undefined (11011) modes each have a private r13 and r14. User (10000) and system (11111) share one r13/r14.
- R5: The current status layout is: sign at bit 31, zero at 30, carry at 29, overflow at 28, normal mask at 7, fast mask at 6, mode at 4:0, and all other bits zero. In a privileged mode, a status write updates the flags, the masks and the mode. A mode code outside the seven is not accepted, and the mode stays as it was.
- R6: In user mode, a status write changes only bits 31:28.
- R7: On exception entry, the old status goes into the target mode's saved status, ret_addr goes into the target mode's r14, the mode switches and the normal mask is set. Fast entry also sets the fast mask. On the following cycle, vec_valid is high with vec_addr equal to VEC_BASE plus 0x04 (undefined), 0x08 (supervisor call), 0x10 (abort), 0x18 (interrupt) or 0x1C (fast).
- R8: Exception priority is abort, then fast interrupt, then interrupt, then undefined, then supervisor call. A fast request is ignored while bit 6 is set, and an interrupt request is ignored while bit 7 is set.
- R9: A return request copies the current mode's saved status into the current status. In user or system mode, it changes nothing.
- R10: In a cycle with exception entry or a return request, the general-register write and the status write of that cycle are discarded.
- R11: spsr_rd shows the saved status of the current mode, and reads zero in user and system modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_sel | input | 4 | Register number for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_sel | input | 4 | Register number for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General-register write enable |
| wr_sel | input | 4 | Register number to write |
| wr_data | input | 32 | Write data |
| psr_wr_en | input | 1 | Current status write enable |
| psr_wr_data | input | 32 | New status value (defined fields only) |
| ret_req | input | 1 | Exception return: restore saved status |
| abt_req | input | 1 | Memory-access abort request |
| fiq_req | input | 1 | Fast interrupt request |
| irq_req | input | 1 | Normal interrupt request |
| und_req | input | 1 | Undefined-instruction request |
| svc_req | input | 1 | Supervisor call request |
| ret_addr | input | 32 | Return address stored in r14 on entry |
| cpsr | output | 32 | Current status word |
| spsr_rd | output | 32 | Saved status of the current mode |
| vec_valid | output | 1 | Vector address valid (cycle after entry) |
| vec_addr | output | 32 | Exception vector address |

## Verification
The bench goes after aliasing: it writes r8 and r13 in one mode and reads them back in another. A wrong bank map would return the other mode's value or corrupt the user copy when fast-interrupt mode returns. It raises competing requests together, for example fast with normal, abort with normal, and undefined with supervisor call, together with masked interrupts. A priority or mask fault would show up as the wrong mode and the wrong vector. It also checks writes issued in the same cycle as an entry or a return, status writes from user mode, and a return from user mode. A design that let any of these through would show changed registers, a gained privilege or a corrupted status word.

// File: rtl/bnk_pkg.sv
// Shared definitions for the mode-banked register file.
// Assumes a 32-bit status word with the field positions below.
package bnk_pkg;

    localparam logic [4:0] MODE_USR = 5'b10000;
    localparam logic [4:0] MODE_FIQ = 5'b10001;
    localparam logic [4:0] MODE_IRQ = 5'b10010;
    localparam logic [4:0] MODE_SVC = 5'b10011;
    localparam logic [4:0] MODE_ABT = 5'b10111;
    localparam logic [4:0] MODE_UND = 5'b11011;
    localparam logic [4:0] MODE_SYS = 5'b11111;

    localparam int PSR_N = 31;
    localparam int PSR_Z = 30;
    localparam int PSR_C = 29;
    localparam int PSR_V = 28;
    localparam int PSR_I = 7;
    localparam int PSR_F = 6;

    localparam logic [7:0] VOFF_UND = 8'h04;
    localparam logic [7:0] VOFF_SVC = 8'h08;
    localparam logic [7:0] VOFF_ABT = 8'h10;
    localparam logic [7:0] VOFF_IRQ = 8'h18;
    localparam logic [7:0] VOFF_FIQ = 8'h1C;

    typedef enum logic [2:0] {
        EXC_NONE, EXC_ABT, EXC_FIQ, EXC_IRQ, EXC_UND, EXC_SVC
    } exc_e;

    // True when the code is one of the seven defined modes.
    function automatic logic mode_legal(input logic [4:0] m);
        return (m == MODE_USR) || (m == MODE_FIQ) || (m == MODE_IRQ) ||
               (m == MODE_SVC) || (m == MODE_ABT) || (m == MODE_UND) ||
               (m == MODE_SYS);
    endfunction

    // Saved-status slot for a mode; user and system have none.
    function automatic logic [2:0] saved_slot(input logic [4:0] m);
        case (m)
            MODE_FIQ: return 3'd0;
            MODE_IRQ: return 3'd1;
            MODE_SVC: return 3'd2;
            MODE_ABT: return 3'd3;
            MODE_UND: return 3'd4;
            default:  return 3'd7;
        endcase
    endfunction

    function automatic logic has_saved(input logic [4:0] m);
        return saved_slot(m) != 3'd7;
    endfunction

endpackage

// File: rtl/bnk_map.sv
// Maps (mode, architectural register number) to a physical index.
// Layout: 0-15 shared set, 16-22 fast r8-r14, then r13/r14 pairs for
// interrupt, supervisor, abort, undefined. Assumes a legal mode.
module bnk_map
    import bnk_pkg::*;
#(
    parameter int NGPR = 31,
    localparam int PW  = $clog2(NGPR)
) (
    input  logic [4:0]    mode,
    input  logic [3:0]    sel,
    output logic [PW-1:0] idx
);
    localparam int FIQ_BASE = 16;
    localparam int IRQ_BASE = FIQ_BASE + 7;
    localparam int SVC_BASE = IRQ_BASE + 2;
    localparam int ABT_BASE = SVC_BASE + 2;
    localparam int UND_BASE = ABT_BASE + 2;

    // Select the physical slot for the register under this mode.
    always_comb begin
        idx = PW'(sel);
        if (sel >= 4'd8 && sel <= 4'd14 && mode == MODE_FIQ) begin
            idx = PW'(FIQ_BASE + int'(sel) - 8);
        end else if (sel == 4'd13 || sel == 4'd14) begin
            case (mode)
                MODE_IRQ: idx = PW'(IRQ_BASE + int'(sel) - 13);
                MODE_SVC: idx = PW'(SVC_BASE + int'(sel) - 13);
                MODE_ABT: idx = PW'(ABT_BASE + int'(sel) - 13);
                MODE_UND: idx = PW'(UND_BASE + int'(sel) - 13);
                default:  idx = PW'(sel);
            endcase
        end
    end
endmodule

// File: rtl/bnk_arb.sv
// Picks one exception from the pending requests by fixed priority,
// applying the interrupt masks, and forms the target mode and vector.
module bnk_arb
    import bnk_pkg::*;
#(
    parameter int          AW       = 32,
    parameter logic [AW-1:0] VEC_BASE = '0
) (
    input  logic          abt_req,
    input  logic          fiq_req,
    input  logic          irq_req,
    input  logic          und_req,
    input  logic          svc_req,
    input  logic          i_mask,
    input  logic          f_mask,
    output logic          take,
    output exc_e          kind,
    output logic [4:0]    tgt_mode,
    output logic [AW-1:0] vec
);
    logic [7:0] voff;

    // Fixed-priority choice: abort, fast, normal, undefined, call.
    always_comb begin
        kind = EXC_NONE;
        if (abt_req)                 kind = EXC_ABT;
        else if (fiq_req && !f_mask) kind = EXC_FIQ;
        else if (irq_req && !i_mask) kind = EXC_IRQ;
        else if (und_req)            kind = EXC_UND;
        else if (svc_req)            kind = EXC_SVC;
    end

    // Target mode and vector offset for the chosen exception.
    always_comb begin
        case (kind)
            EXC_ABT: begin tgt_mode = MODE_ABT; voff = VOFF_ABT; end
            EXC_FIQ: begin tgt_mode = MODE_FIQ; voff = VOFF_FIQ; end
            EXC_IRQ: begin tgt_mode = MODE_IRQ; voff = VOFF_IRQ; end
            EXC_UND: begin tgt_mode = MODE_UND; voff = VOFF_UND; end
            EXC_SVC: begin tgt_mode = MODE_SVC; voff = VOFF_SVC; end
            default: begin tgt_mode = MODE_SVC; voff = 8'h00;    end
        endcase
    end

    assign take = (kind != EXC_NONE);
    assign vec  = VEC_BASE + AW'(voff);
endmodule

// File: rtl/mode_banked_regs.sv
// Top of the mode-banked register file: 31 general registers, the
// current status word and five saved status words. Reads are
// combinational under the current mode; entry, return and writes act on
// the rising edge. Assumes at most one write port user per cycle.
module mode_banked_regs
    import bnk_pkg::*;
#(
    parameter int          DW       = 32,
    parameter logic [DW-1:0] VEC_BASE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    rd_a_sel,
    output logic [DW-1:0] rd_a_data,
    input  logic [3:0]    rd_b_sel,
    output logic [DW-1:0] rd_b_data,
    input  logic          wr_en,
    input  logic [3:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          psr_wr_en,
    input  logic [31:0]   psr_wr_data,
    input  logic          ret_req,
    input  logic          abt_req,
    input  logic          fiq_req,
    input  logic          irq_req,
    input  logic          und_req,
    input  logic          svc_req,
    input  logic [DW-1:0] ret_addr,
    output logic [31:0]   cpsr,
    output logic [31:0]   spsr_rd,
    output logic          vec_valid,
    output logic [DW-1:0] vec_addr
);
    localparam int NGPR   = 31;
    localparam int PW     = $clog2(NGPR);
    localparam int NSAVED = 5;
    localparam logic [31:0] PSR_RESET = {24'h0, 1'b1, 1'b1, 1'b0, MODE_SVC};

    logic [DW-1:0] gpr_q  [NGPR];
    logic [31:0]   spsr_q [NSAVED];
    logic [31:0]   cpsr_q;
    logic          vec_valid_q;
    logic [DW-1:0] vec_addr_q;

    logic [4:0]    cur_mode;
    logic [PW-1:0] idx_a, idx_b, idx_w, idx_lr;
    logic          take;
    exc_e          kind;
    logic [4:0]    tgt_mode;
    logic [DW-1:0] vec_next;
    logic [2:0]    cur_slot, tgt_slot;
    logic          unused_psr_bits;

    assign cur_mode        = cpsr_q[4:0];
    assign cur_slot        = saved_slot(cur_mode);
    assign tgt_slot        = saved_slot(tgt_mode);
    assign unused_psr_bits = ^{psr_wr_data[27:8], psr_wr_data[5]};

    bnk_map #(.NGPR(NGPR)) u_map_a  (.mode(cur_mode), .sel(rd_a_sel), .idx(idx_a));
    bnk_map #(.NGPR(NGPR)) u_map_b  (.mode(cur_mode), .sel(rd_b_sel), .idx(idx_b));
    bnk_map #(.NGPR(NGPR)) u_map_w  (.mode(cur_mode), .sel(wr_sel),   .idx(idx_w));
    bnk_map #(.NGPR(NGPR)) u_map_lr (.mode(tgt_mode), .sel(4'd14),    .idx(idx_lr));

    bnk_arb #(.AW(DW), .VEC_BASE(VEC_BASE)) u_arb (
        .abt_req (abt_req),
        .fiq_req (fiq_req),
        .irq_req (irq_req),
        .und_req (und_req),
        .svc_req (svc_req),
        .i_mask  (cpsr_q[PSR_I]),
        .f_mask  (cpsr_q[PSR_F]),
        .take    (take),
        .kind    (kind),
        .tgt_mode(tgt_mode),
        .vec     (vec_next)
    );

    // General registers: entry writes the target link register, else a normal write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NGPR; i++) gpr_q[i] <= '0;
        end else if (take) begin
            gpr_q[idx_lr] <= ret_addr;
        end else if (wr_en && !ret_req) begin
            gpr_q[idx_w] <= wr_data;
        end
    end

    // Saved status words: capture the current status on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSAVED; i++) spsr_q[i] <= '0;
        end else if (take) begin
            spsr_q[tgt_slot] <= cpsr_q;
        end
    end

    // Current status: entry, then return, then software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpsr_q <= PSR_RESET;
        end else if (take) begin
            cpsr_q[4:0]   <= tgt_mode;
            cpsr_q[PSR_I] <= 1'b1;
            if (kind == EXC_FIQ) cpsr_q[PSR_F] <= 1'b1;
        end else if (ret_req) begin
            if (has_saved(cur_mode)) cpsr_q <= spsr_q[cur_slot];
        end else if (psr_wr_en) begin
            cpsr_q[31:28] <= psr_wr_data[31:28];
            if (cur_mode != MODE_USR) begin
                cpsr_q[PSR_I] <= psr_wr_data[PSR_I];
                cpsr_q[PSR_F] <= psr_wr_data[PSR_F];
                if (mode_legal(psr_wr_data[4:0])) cpsr_q[4:0] <= psr_wr_data[4:0];
            end
        end
    end

    // Vector output: one-cycle valid pulse after entry, address held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid_q <= 1'b0;
            vec_addr_q  <= '0;
        end else begin
            vec_valid_q <= take;
            if (take) vec_addr_q <= vec_next;
        end
    end

    assign rd_a_data = gpr_q[idx_a];
    assign rd_b_data = gpr_q[idx_b];
    assign cpsr      = cpsr_q;
    assign spsr_rd   = has_saved(cur_mode) ? spsr_q[cur_slot] : 32'h0;
    assign vec_valid = vec_valid_q;
    assign vec_addr  = vec_addr_q;

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_legal(cpsr_q[4:0])); // R5
    AST_ENTRY_MASKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> cpsr_q[PSR_I]); // R7
    AST_FIQ_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (take && kind == EXC_FIQ) |=> (cpsr_q[PSR_F] && cpsr_q[4:0] == MODE_FIQ)); // R7
    AST_ENTRY_SAVES_PSR: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (spsr_rd == $past(cpsr_q))); // R7
    AST_VEC_AFTER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> vec_valid); // R7
    AST_USER_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == MODE_USR && psr_wr_en && !take && !ret_req) |=> $stable(cpsr_q[7:0])); // R6
    AST_FIQ_OVER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_req && !cpsr_q[PSR_F] && irq_req && !abt_req) |=> (cpsr_q[4:0] == MODE_FIQ)); // R8
    AST_USER_RET_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !take && !has_saved(cur_mode)) |=> $stable(cpsr_q)); // R9
endmodule

// File: tb/sim_mode_banked_regs.sv
`timescale 1ns/1ps
// Bench: behavioural per-bank reference model compared every cycle.
module sim_mode_banked_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0, psr_wr_data = '0, ret_addr = '0;
    logic        wr_en = 0, psr_wr_en = 0, ret_req = 0;
    logic        abt_req = 0, fiq_req = 0, irq_req = 0, und_req = 0, svc_req = 0;
    logic [31:0] cpsr, spsr_rd, vec_addr;
    logic        vec_valid;

    always #2.5 clk = ~clk;

    mode_banked_regs u0 (.*);

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;

    // Reference state: six banks of sixteen registers, saved words per bank.
    logic [31:0] m_reg [6][16];
    logic [31:0] m_spsr [6];
    logic [31:0] m_cpsr, m_vec;
    logic        m_vv;

    function automatic int bank_of(input logic [4:0] m, input int r);
        if (r < 8 || r == 15) return 0;
        if (m == 5'b10001) return 1;
        if (r < 13) return 0;
        case (m)
            5'b10010: return 2;
            5'b10011: return 3;
            5'b10111: return 4;
            5'b11011: return 5;
            default:  return 0;
        endcase
    endfunction

    function automatic bit legal(input logic [4:0] m);
        return m inside {5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111};
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int b = 0; b < 6; b++) begin
            m_spsr[b] = '0;
            for (int r = 0; r < 16; r++) m_reg[b][r] = '0;
        end
        m_cpsr = 32'h0000_00D3;
        m_vv = 0;
        m_vec = '0;
    endtask

    task automatic model_clock();
        int k;
        logic [4:0] m, t;
        m = m_cpsr[4:0];
        k = 0;
        if (abt_req) k = 1;
        else if (fiq_req && !m_cpsr[6]) k = 2;
        else if (irq_req && !m_cpsr[7]) k = 3;
        else if (und_req) k = 4;
        else if (svc_req) k = 5;
        if (k != 0) begin
            case (k)
                1: begin t = 5'b10111; m_vec = 32'h10; end
                2: begin t = 5'b10001; m_vec = 32'h1C; end
                3: begin t = 5'b10010; m_vec = 32'h18; end
                4: begin t = 5'b11011; m_vec = 32'h04; end
                default: begin t = 5'b10011; m_vec = 32'h08; end
            endcase
            m_spsr[bank_of(t, 13)] = m_cpsr;
            m_reg[bank_of(t, 14)][14] = ret_addr;
            m_cpsr[4:0] = t;
            m_cpsr[7] = 1'b1;
            if (k == 2) m_cpsr[6] = 1'b1;
            m_vv = 1;
        end else begin
            m_vv = 0;
            if (ret_req) begin
                if (bank_of(m, 13) != 0) m_cpsr = m_spsr[bank_of(m, 13)];
            end else begin
                if (wr_en) m_reg[bank_of(m, int'(wr_sel))][wr_sel] = wr_data;
                if (psr_wr_en) begin
                    m_cpsr[31:28] = psr_wr_data[31:28];
                    if (m != 5'b10000) begin
                        m_cpsr[7:6] = psr_wr_data[7:6];
                        if (legal(psr_wr_data[4:0])) m_cpsr[4:0] = psr_wr_data[4:0];
                    end
                end
            end
        end
    endtask

    // One cycle: compare outputs against the model, clock, update the model.
    task automatic step(input string tag);
        logic [4:0] m;
        rd_a_sel = 4'(cyc);
        rd_b_sel = 4'(cyc * 5 + 3);
        cyc++;
        #1;
        m = m_cpsr[4:0];
        check(tag, "rd_a", rd_a_data, m_reg[bank_of(m, int'(rd_a_sel))][rd_a_sel]);
        check(tag, "rd_b", rd_b_data, m_reg[bank_of(m, int'(rd_b_sel))][rd_b_sel]);
        check(tag, "cpsr", cpsr, m_cpsr);
        check(tag, "spsr_rd R11", spsr_rd, (bank_of(m, 13) != 0) ? m_spsr[bank_of(m, 13)] : 32'h0);
        check(tag, "vec_valid", {31'h0, vec_valid}, {31'h0, m_vv});
        if (m_vv) check(tag, "vec_addr", vec_addr, m_vec);
        @(posedge clk);
        model_clock();
        @(negedge clk);
        wr_en = 0; psr_wr_en = 0; ret_req = 0;
        abt_req = 0; fiq_req = 0; irq_req = 0; und_req = 0; svc_req = 0;
    endtask

    task automatic wr(input int r, input logic [31:0] d, input string tag);
        wr_en = 1; wr_sel = 4'(r); wr_data = d;
        step(tag);
    endtask

    task automatic psrw(input logic [31:0] d, input string tag);
        psr_wr_en = 1; psr_wr_data = d;
        step(tag);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        step("R1");
        for (int r = 0; r < 16; r++) wr(r, 32'hA000_0000 + r, "R2");
        psrw(32'hA000_001F, "R5");                 // system mode, masks clear
        wr(13, 32'h5000_0013, "R4");
        wr(14, 32'h5000_0014, "R4");
        wr(8,  32'h5000_0008, "R3");
        psrw(32'h4000_0014, "R5");                 // illegal mode code kept out
        fiq_req = 1; irq_req = 1; ret_addr = 32'h100; step("R8");
        for (int r = 8; r < 15; r++) wr(r, 32'hF000_0000 + r, "R3");
        for (int i = 0; i < 16; i++) step("R3");
        ret_req = 1; wr_en = 1; wr_sel = 4'd2; wr_data = 32'hDEAD_0002; step("R10");
        for (int i = 0; i < 16; i++) step("R3");
        irq_req = 1; abt_req = 1; ret_addr = 32'h200; step("R8");
        psrw(32'h0000_0017, "R5");
        irq_req = 1; ret_addr = 32'h300; step("R8");
        irq_req = 1; step("R8");                   // masked now
        und_req = 1; svc_req = 1; wr_en = 1; wr_sel = 4'd3; wr_data = 32'hBAD0_0003;
        psr_wr_en = 1; psr_wr_data = 32'hF000_001F; ret_addr = 32'h400; step("R10");
        ret_req = 1; step("R9");
        ret_req = 1; step("R9");
        psrw(32'h1000_0010, "R6");                 // enter user mode
        psrw(32'hF000_00DF, "R6");                 // only flags may change
        ret_req = 1; step("R9");
        wr(13, 32'h7000_0013, "R4");
        svc_req = 1; ret_addr = 32'h500; step("R7");
        fiq_req = 1; ret_addr = 32'h600; step("R7");
        for (int i = 0; i < 16; i++) step("R11");
        ret_req = 1; step("R9");
        for (int i = 0; i < 16; i++) step("R4");
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule